// File: doc/BRIEF.md
# Chained Scatter-Gather DMA Channel Sequencer

This block controls one DMA channel. Software programs a mode word, a PCI-side address, a local-side address, a byte count and a descriptor pointer through a small register port, then writes a command byte to start the channel. The channel cuts the transfer into bursts of at most `MAX_BURST` bytes. It hands each burst to an abstract transfer port as a request/acknowledge pair. The PCI and local bus protocols, the FIFOs and the data path lie outside the block.

With chaining enabled, the pointer names a 16-byte descriptor in memory. The channel reads the descriptor's four words through a descriptor memory port into its working registers and runs that segment. It then follows the link word to the next descriptor, until a link word carries the last-link flag. Each link word also picks the memory side for the next fetch, the transfer direction and a per-segment interrupt. An optional mode clears each finished descriptor's count word in memory. An abort ends an active run once the handshake in flight completes. The channel interrupt is a sticky flag, routed to either the PCI side or the local side.

Top module: `sgdma_channel`

## Requirements
- R1: After reset the status byte reads 0x10 (done set, enable clear), no descriptor or transfer request is raised, and both interrupt outputs are low.
- R2: The channel accepts a start only when it is idle and the same status-byte write also sets bit 0 (enable). A start without the enable bit does nothing. Writes to register indices 0 to 4 are ignored while the channel is busy.
- R3: A transfer of N bytes produces bursts of min(remaining, `MAX_BURST`) bytes. Each request holds its values until it is acknowledged. The PCI address advances by each burst length. Without chaining, the direction comes from bit 3 of the pointer register (1 = local to PCI).
- R4: When mode bit 11 is set, the local address stays constant across all bursts. Otherwise it advances like the PCI address.
- R5: With mode bit 9 set, a start fetches four words (PCI address, local address, byte count, link) from address {pointer[31:4], 4'b0000} upward, one word per handshake. Pointer bit 0 selects the fetch side (1 = PCI side, 0 = local side). The channel follows link words (next address in bits 31:4, side in bit 0, direction in bit 3) until it finishes a segment whose link has bit 1 set.
- R6: The byte count register keeps only its low 23 bits.
- R7: Done (status bit 4) reads 0 while a transfer or chain is active. It reads 1 again after completion or after an abort has taken effect.
- R8: The interrupt flag is set when a run completes with mode bit 10 set, or when a chained segment finishes whose link word has bit 2 set. It drives `irq_pci` if mode bit 17 is 1 and `irq_local` otherwise. Writing status bit 3 clears it.
- R9: With mode bits 9 and 16 set, after each finished segment the channel issues a zero write to that descriptor's count word (descriptor base + 8) on the fetch side it came from.
- R10: An abort (status bit 2) written while idle has no effect. Written while busy, it lets the handshake in flight finish, raises no further request, and done returns by the cycle after that handshake.
- R11: Register indices are: 0 mode, 1 PCI address, 2 local address, 3 byte count, 4 descriptor pointer, 5 status byte. The status byte reads enable in bit 0 and done in bit 4, with bits 1 to 3 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register index (R11) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| desc_req | output | 1 | Descriptor memory request |
| desc_we | output | 1 | Request is a zero write to the count word |
| desc_space | output | 1 | Descriptor side: 1 PCI, 0 local |
| desc_addr | output | ADDR_W | Descriptor word byte address |
| desc_rdata | input | 32 | Read word, valid with desc_ack |
| desc_ack | input | 1 | Descriptor request accepted |
| xfer_req | output | 1 | Burst request |
| xfer_to_pci | output | 1 | Burst direction: 1 local to PCI |
| xfer_pci_addr | output | ADDR_W | PCI-side burst address |
| xfer_loc_addr | output | ADDR_W | Local-side burst address |
| xfer_len | output | clog2(MAX_BURST+1) | Burst length in bytes |
| xfer_ack | input | 1 | Burst accepted |
| irq_pci | output | 1 | Channel interrupt, PCI side |
| irq_local | output | 1 | Channel interrupt, local side |

## Verification
On every cycle, the embedded assertions check that both request handshakes hold their values until acknowledged, and that burst lengths stay within one to `MAX_BURST`. They also check that hold-constant freezes the local address across a handshake, that clear writes target the count word, and that a pending abort with no handshake in flight ends the run at the next edge. The interrupt flag's set and clear priorities and the ignored unenabled start are also checked every cycle. Only the directed scenarios can show the full burst sequence and final register values, link following across both fetch sides, the zeroed count words in memory, interrupt routing, and the ignoring of register writes while busy.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  // register index map
  localparam int REG_MODE = 0;
  localparam int REG_PCI  = 1;
  localparam int REG_LOC  = 2;
  localparam int REG_CNT  = 3;
  localparam int REG_PTR  = 4;
  localparam int REG_CSR  = 5;

  // mode word bits
  localparam int MODE_CHAIN    = 9;
  localparam int MODE_DONE_IE  = 10;
  localparam int MODE_HOLD_LOC = 11;
  localparam int MODE_CLR_CNT  = 16;
  localparam int MODE_IRQ_PCI  = 17;

  // link word bits
  localparam int LNK_SIDE_PCI = 0;
  localparam int LNK_LAST     = 1;
  localparam int LNK_TC_IRQ   = 2;
  localparam int LNK_TO_PCI   = 3;

  // status byte bits
  localparam int CSR_EN      = 0;
  localparam int CSR_GO      = 1;
  localparam int CSR_STOP    = 2;
  localparam int CSR_IRQ_CLR = 3;
  localparam int CSR_DONE    = 4;

  // descriptor layout
  localparam int DESC_WORDS   = 4;
  localparam int DESC_CNT_IDX = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MOVE,
    ST_SEGEND,
    ST_CLEAR
  } chan_state_e;

endpackage

// File: rtl/sgdma_burst.sv
module sgdma_burst #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 23,
  parameter int MAX_BURST = 32,
  parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic [CNT_W-1:0]  remain,
  input  logic [ADDR_W-1:0] pci_cur,
  input  logic [ADDR_W-1:0] loc_cur,
  input  logic              hold_loc,
  output logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] pci_nxt,
  output logic [ADDR_W-1:0] loc_nxt,
  output logic [CNT_W-1:0]  remain_nxt,
  output logic              last
);

  // bytes moved by the next burst
  function automatic logic [LEN_W-1:0] burst_size(input logic [CNT_W-1:0] r);
    if (r >= CNT_W'(MAX_BURST)) return LEN_W'(MAX_BURST);
    return LEN_W'(r);
  endfunction

  // address after a burst of n bytes
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [LEN_W-1:0] n);
    return a + ADDR_W'(n);
  endfunction

  always_comb begin
    len        = burst_size(remain);
    pci_nxt    = step_addr(pci_cur, len);
    loc_nxt    = hold_loc ? loc_cur : step_addr(loc_cur, len);
    remain_nxt = remain - CNT_W'(len);
    last       = (remain_nxt == '0);
  end

endmodule

// File: rtl/sgdma_fetch.sv
module sgdma_fetch #(
  parameter int ADDR_W  = 32,
  parameter int WORDS   = 4,
  parameter int CLR_IDX = 2,
  parameter int IDX_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_base,
  input  logic [ADDR_W-5:0] base_hi,
  input  logic              base_pci,
  input  logic              fetching,
  input  logic              clearing,
  input  logic              ack,
  output logic [ADDR_W-1:0] addr,
  output logic              space_pci,
  output logic [IDX_W-1:0]  word_idx,
  output logic              last_word
);

  logic [ADDR_W-5:0] base_q;
  logic              side_q;
  logic [IDX_W-1:0]  idx_q;

  // byte address of word i of the descriptor at 16-byte slot b
  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-5:0] b,
                                                  input logic [IDX_W-1:0] i);
    return {b, 4'b0000} + (ADDR_W'(i) << 2);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      side_q <= 1'b0;
    end else if (load_base) begin
      base_q <= base_hi;
      side_q <= base_pci;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= '0;
    else if (!fetching) idx_q <= '0;
    else if (ack)      idx_q <= idx_q + 1'b1;
  end

  always_comb begin
    addr      = word_addr(base_q, clearing ? IDX_W'(CLR_IDX) : idx_q);
    space_pci = side_q;
    word_idx  = idx_q;
    last_word = (idx_q == IDX_W'(WORDS - 1));
  end

endmodule

// File: rtl/sgdma_irq.sv
module sgdma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic route_pci,
  output logic irq_pci,
  output logic irq_local
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end

  assign irq_pci   = flag_q &  route_pci;
  assign irq_local = flag_q & ~route_pci;

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> (!irq_pci && !irq_local));

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> (irq_pci || irq_local));

endmodule

// File: rtl/sgdma_channel.sv
module sgdma_channel
  import sgdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 23,
  parameter int MAX_BURST = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_wr,
  input  logic [2:0]                       reg_sel,
  input  logic [31:0]                      reg_wdata,
  output logic [31:0]                      reg_rdata,
  output logic                             desc_req,
  output logic                             desc_we,
  output logic                             desc_space,
  output logic [ADDR_W-1:0]                desc_addr,
  input  logic [31:0]                      desc_rdata,
  input  logic                             desc_ack,
  output logic                             xfer_req,
  output logic                             xfer_to_pci,
  output logic [ADDR_W-1:0]                xfer_pci_addr,
  output logic [ADDR_W-1:0]                xfer_loc_addr,
  output logic [$clog2(MAX_BURST+1)-1:0]   xfer_len,
  input  logic                             xfer_ack,
  output logic                             irq_pci,
  output logic                             irq_local
);

  localparam int LEN_W = $clog2(MAX_BURST + 1);
  localparam int IDX_W = $clog2(DESC_WORDS);

  chan_state_e       st_q, st_d;
  logic [31:0]       mode_q;
  logic [ADDR_W-1:0] pci_q, loc_q, ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              en_q, abort_q;

  // named internal events
  logic idle, csr_wr, start_acc, abort_req, irq_clr;
  logic chain_on, chain_end, fetch_act, clear_act;
  logic word_hs, move_hs, clear_hs, seg_ok, want_clear;
  logic tc_evt, fin_evt, next_evt, load_base, irq_set;

  // burst arithmetic
  logic [LEN_W-1:0]  b_len;
  logic [ADDR_W-1:0] b_pci, b_loc;
  logic [CNT_W-1:0]  b_cnt;
  logic              b_last;

  // fetch unit
  logic [IDX_W-1:0]  f_idx;
  logic              f_last;

  always_comb begin
    idle       = (st_q == ST_IDLE);
    csr_wr     = reg_wr && (reg_sel == 3'(REG_CSR));
    start_acc  = csr_wr && reg_wdata[CSR_GO] && reg_wdata[CSR_EN] && idle;
    abort_req  = csr_wr && reg_wdata[CSR_STOP] && !idle;
    irq_clr    = csr_wr && reg_wdata[CSR_IRQ_CLR];
    chain_on   = mode_q[MODE_CHAIN];
    chain_end  = !chain_on || ptr_q[LNK_LAST];
    fetch_act  = (st_q == ST_FETCH);
    clear_act  = (st_q == ST_CLEAR);
    word_hs    = fetch_act && desc_ack;
    move_hs    = (st_q == ST_MOVE) && xfer_ack;
    clear_hs   = clear_act && desc_ack;
    seg_ok     = (st_q == ST_SEGEND) && !abort_q;
    want_clear = chain_on && mode_q[MODE_CLR_CNT];
    tc_evt     = seg_ok && chain_on && ptr_q[LNK_TC_IRQ];
    fin_evt    = (seg_ok && !want_clear && chain_end) ||
                 (clear_hs && !abort_q && chain_end);
    next_evt   = (seg_ok && !want_clear && !chain_end) ||
                 (clear_hs && !abort_q && !chain_end);
    load_base  = (start_acc && chain_on) || next_evt;
    irq_set    = tc_evt || (fin_evt && mode_q[MODE_DONE_IE]);
  end

  sgdma_burst #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)
  ) u_burst (
    .remain    (cnt_q),
    .pci_cur   (pci_q),
    .loc_cur   (loc_q),
    .hold_loc  (mode_q[MODE_HOLD_LOC]),
    .len       (b_len),
    .pci_nxt   (b_pci),
    .loc_nxt   (b_loc),
    .remain_nxt(b_cnt),
    .last      (b_last)
  );

  sgdma_fetch #(
    .ADDR_W(ADDR_W), .WORDS(DESC_WORDS), .CLR_IDX(DESC_CNT_IDX), .IDX_W(IDX_W)
  ) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_base(load_base),
    .base_hi  (ptr_q[ADDR_W-1:4]),
    .base_pci (ptr_q[LNK_SIDE_PCI]),
    .fetching (fetch_act),
    .clearing (clear_act),
    .ack      (desc_ack),
    .addr     (desc_addr),
    .space_pci(desc_space),
    .word_idx (f_idx),
    .last_word(f_last)
  );

  sgdma_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (irq_set),
    .clr_evt  (irq_clr),
    .route_pci(mode_q[MODE_IRQ_PCI]),
    .irq_pci  (irq_pci),
    .irq_local(irq_local)
  );

  // sequencer
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:
        if (start_acc) begin
          if (chain_on)           st_d = ST_FETCH;
          else if (cnt_q == '0)   st_d = ST_SEGEND;
          else                    st_d = ST_MOVE;
        end
      ST_FETCH:
        if (word_hs) begin
          if (abort_q)            st_d = ST_IDLE;
          else if (f_last)        st_d = (cnt_q == '0) ? ST_SEGEND : ST_MOVE;
        end
      ST_MOVE:
        if (move_hs) begin
          if (abort_q)            st_d = ST_IDLE;
          else if (b_last)        st_d = ST_SEGEND;
        end
      ST_SEGEND:
        if (abort_q)              st_d = ST_IDLE;
        else if (want_clear)      st_d = ST_CLEAR;
        else if (!chain_end)      st_d = ST_FETCH;
        else                      st_d = ST_IDLE;
      ST_CLEAR:
        if (clear_hs) begin
          if (abort_q || chain_end) st_d = ST_IDLE;
          else                      st_d = ST_FETCH;
        end
      default:                    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      abort_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      abort_q <= idle ? 1'b0 : (abort_q | abort_req);
      if (csr_wr) en_q <= reg_wdata[CSR_EN];
    end
  end

  // working registers: software writes when idle, descriptor loads, burst updates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pci_q  <= '0;
      loc_q  <= '0;
      cnt_q  <= '0;
      ptr_q  <= '0;
    end else if (reg_wr && idle) begin
      case (reg_sel)
        3'(REG_MODE): mode_q <= reg_wdata;
        3'(REG_PCI):  pci_q  <= reg_wdata[ADDR_W-1:0];
        3'(REG_LOC):  loc_q  <= reg_wdata[ADDR_W-1:0];
        3'(REG_CNT):  cnt_q  <= reg_wdata[CNT_W-1:0];
        3'(REG_PTR):  ptr_q  <= reg_wdata[ADDR_W-1:0];
        default: ;
      endcase
    end else if (word_hs) begin
      case (f_idx)
        IDX_W'(0): pci_q <= desc_rdata[ADDR_W-1:0];
        IDX_W'(1): loc_q <= desc_rdata[ADDR_W-1:0];
        IDX_W'(2): cnt_q <= desc_rdata[CNT_W-1:0];
        default:   ptr_q <= desc_rdata[ADDR_W-1:0];
      endcase
    end else if (move_hs) begin
      pci_q <= b_pci;
      loc_q <= b_loc;
      cnt_q <= b_cnt;
    end
  end

  // outputs
  always_comb begin
    desc_req      = fetch_act || clear_act;
    desc_we       = clear_act;
    xfer_req      = (st_q == ST_MOVE);
    xfer_to_pci   = ptr_q[LNK_TO_PCI];
    xfer_pci_addr = pci_q;
    xfer_loc_addr = loc_q;
    xfer_len      = b_len;
    case (reg_sel)
      3'(REG_MODE): reg_rdata = mode_q;
      3'(REG_PCI):  reg_rdata = 32'(pci_q);
      3'(REG_LOC):  reg_rdata = 32'(loc_q);
      3'(REG_CNT):  reg_rdata = 32'(cnt_q);
      3'(REG_PTR):  reg_rdata = 32'(ptr_q);
      3'(REG_CSR):  reg_rdata = 32'({idle, 3'b000, en_q});
      default:      reg_rdata = '0;
    endcase
  end

  // R3
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_pci_addr) &&
                                 $stable(xfer_loc_addr) && $stable(xfer_len)));

  // R3
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (xfer_len != '0 && int'(xfer_len) <= MAX_BURST));

  // R4
  hold_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack && mode_q[MODE_HOLD_LOC]) |=> $stable(xfer_loc_addr));

  // R5
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && !desc_ack) |=> (desc_req && $stable(desc_addr) && $stable(desc_space)));

  // R9
  clear_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && desc_we) |-> (desc_addr[3:0] == 4'h8));

  // R10
  abort_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q && !xfer_req && !desc_req && !idle) |=> idle);

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && reg_wdata[CSR_GO] && !reg_wdata[CSR_EN] && idle) |=>
      (idle && !xfer_req && !desc_req));

endmodule

// File: tb/sgdma_channel_test.sv
module sgdma_channel_test;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic desc_req, desc_we, desc_space;
  logic [31:0] desc_addr;
  logic [31:0] desc_rdata = '0;
  logic desc_ack = 1'b0;
  logic xfer_req, xfer_to_pci;
  logic [31:0] xfer_pci_addr, xfer_loc_addr;
  logic [LEN_W-1:0] xfer_len;
  logic xfer_ack = 1'b0;
  logic irq_pci, irq_local;

  int checks = 0;
  int errors = 0;
  logic ack_en = 1'b1;

  logic [31:0] mem_pci [64];
  logic [31:0] mem_loc [64];
  int n_xfer = 0;
  logic [31:0] lg_pci [16];
  logic [31:0] lg_loc [16];
  int          lg_len [16];
  logic        lg_dir [16];
  int n_fetch = 0;
  logic [31:0] fa_addr [16];
  logic        fa_side [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  sgdma_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .desc_req(desc_req), .desc_we(desc_we), .desc_space(desc_space),
    .desc_addr(desc_addr), .desc_rdata(desc_rdata), .desc_ack(desc_ack),
    .xfer_req(xfer_req), .xfer_to_pci(xfer_to_pci),
    .xfer_pci_addr(xfer_pci_addr), .xfer_loc_addr(xfer_loc_addr),
    .xfer_len(xfer_len), .xfer_ack(xfer_ack),
    .irq_pci(irq_pci), .irq_local(irq_local)
  );

  // responders for the descriptor and transfer ports
  initial begin
    forever begin
      @(negedge clk);
      desc_ack   = desc_req;
      desc_rdata = desc_space ? mem_pci[desc_addr[7:2]] : mem_loc[desc_addr[7:2]];
      if (desc_req && desc_we) begin
        if (desc_space) mem_pci[desc_addr[7:2]] = '0;
        else            mem_loc[desc_addr[7:2]] = '0;
      end else if (desc_req && n_fetch < 16) begin
        fa_addr[n_fetch] = desc_addr;
        fa_side[n_fetch] = desc_space;
        n_fetch++;
      end
      xfer_ack = xfer_req && ack_en;
      if (xfer_ack && n_xfer < 16) begin
        lg_pci[n_xfer] = xfer_pci_addr;
        lg_loc[n_xfer] = xfer_loc_addr;
        lg_len[n_xfer] = int'(xfer_len);
        lg_dir[n_xfer] = xfer_to_pci;
        n_xfer++;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_sel = 3'(sel);
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 3'(sel);
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(input int limit, output int waited);
    logic [31:0] s;
    waited = 0;
    rd(5, s);
    while (!s[4] && waited < limit) begin
      rd(5, s);
      waited++;
    end
  endtask

  task automatic clear_logs();
    n_xfer = 0;
    n_fetch = 0;
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(5, s);
    chk("R1 status after reset", s, 32'h10);
    chk("R11 status bits 1-3 read zero", {29'd0, s[3:1]}, 32'h0);
    chk("R1 no requests", {30'd0, desc_req, xfer_req}, 32'h0);
    chk("R1 irq low", {30'd0, irq_pci, irq_local}, 32'h0);
  endtask

  task automatic t_count_mask();
    logic [31:0] v;
    wr(3, 32'hFFFF_FFFF);
    rd(3, v);
    chk("R6 count keeps 23 bits", v, 32'h007F_FFFF);
    wr(3, 32'h0);
  endtask

  task automatic t_start_no_enable();
    logic [31:0] s;
    clear_logs();
    wr(0, 32'h0);
    wr(3, 32'd64);
    wr(5, 32'h02);
    repeat (5) @(negedge clk);
    rd(5, s);
    chk("R2 start without enable ignored", s, 32'h10);
    chk("R2 no burst issued", 32'(n_xfer), 32'd0);
  endtask

  task automatic t_idle_abort();
    logic [31:0] s, v;
    clear_logs();
    wr(1, 32'h1234);
    wr(5, 32'h04);
    repeat (4) @(negedge clk);
    rd(5, s);
    chk("R10 idle abort leaves status", s, 32'h10);
    rd(1, v);
    chk("R10 idle abort leaves PCI address", v, 32'h1234);
    chk("R10 idle abort no bursts", 32'(n_xfer), 32'd0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    int w;
    clear_logs();
    wr(0, 32'h0000_0400);
    wr(1, 32'h1000);
    wr(2, 32'h2000);
    wr(3, 32'd100);
    wr(4, 32'h8);
    wr(5, 32'h03);
    wait_done(200, w);
    chk("R3 burst count", 32'(n_xfer), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 burst length", 32'(lg_len[i]), (i == 3) ? 32'd4 : 32'd32);
      chk("R3 PCI address advance", lg_pci[i], 32'h1000 + 32'(32 * i));
      chk("R4 local address advance", lg_loc[i], 32'h2000 + 32'(32 * i));
      chk("R3 direction from pointer bit 3", 32'(lg_dir[i]), 32'd1);
    end
    rd(1, v); chk("R3 final PCI address", v, 32'h1064);
    rd(3, v); chk("R3 final count", v, 32'h0);
    rd(5, v); chk("R7 done and enable after run", v, 32'h11);
    chk("R8 done irq routed local", {30'd0, irq_pci, irq_local}, 32'h1);
    wr(5, 32'h08);
    @(negedge clk);
    chk("R8 irq cleared", {30'd0, irq_pci, irq_local}, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    int w;
    clear_logs();
    wr(0, 32'h0002_0C00);
    wr(1, 32'h4000);
    wr(2, 32'h7000);
    wr(3, 32'd64);
    wr(4, 32'h0);
    wr(5, 32'h03);
    wait_done(200, w);
    chk("R4 hold burst count", 32'(n_xfer), 32'd2);
    chk("R4 local held burst 1", lg_loc[1], 32'h7000);
    chk("R3 PCI advances under hold", lg_pci[1], 32'h4020);
    chk("R3 direction local side", 32'(lg_dir[0]), 32'd0);
    rd(2, v); chk("R4 local register held", v, 32'h7000);
    chk("R8 done irq routed PCI", {30'd0, irq_pci, irq_local}, 32'h2);
    wr(5, 32'h08);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int w;
    clear_logs();
    for (int i = 0; i < 64; i++) begin
      mem_pci[i] = 32'hBAD0_0000 + 32'(i);
      mem_loc[i] = 32'hBAD1_0000 + 32'(i);
    end
    mem_pci[16] = 32'h3000; mem_pci[17] = 32'h100;
    mem_pci[18] = 32'd40;   mem_pci[19] = 32'h0000_0084;
    mem_loc[32] = 32'h5000; mem_loc[33] = 32'h600;
    mem_loc[34] = 32'd8;    mem_loc[35] = 32'h0000_000A;
    wr(0, 32'h0001_0200);
    wr(4, 32'h41);
    wr(5, 32'h03);
    @(negedge clk);
    rd(5, v);
    chk("R7 done low while chain active", {31'd0, v[4]}, 32'd0);
    wait_done(300, w);
    chk("R5 chain burst count", 32'(n_xfer), 32'd3);
    chk("R5 seg A burst 0 PCI", lg_pci[0], 32'h3000);
    chk("R5 seg A burst 1 len", 32'(lg_len[1]), 32'd8);
    chk("R5 seg A burst 1 local", lg_loc[1], 32'h120);
    chk("R5 seg B PCI", lg_pci[2], 32'h5000);
    chk("R5 seg B local", lg_loc[2], 32'h600);
    chk("R5 seg A direction", 32'(lg_dir[0]), 32'd0);
    chk("R5 seg B direction", 32'(lg_dir[2]), 32'd1);
    chk("R5 word fetches", 32'(n_fetch), 32'd8);
    chk("R5 first fetch address", fa_addr[0], 32'h40);
    chk("R5 first fetch side PCI", 32'(fa_side[0]), 32'd1);
    chk("R5 second descriptor address", fa_addr[4], 32'h80);
    chk("R5 second descriptor side local", 32'(fa_side[4]), 32'd0);
    chk("R9 seg A count zeroed", mem_pci[18], 32'h0);
    chk("R9 seg B count zeroed", mem_loc[34], 32'h0);
    chk("R9 neighbour word untouched", mem_pci[19], 32'h84);
    rd(4, v); chk("R5 pointer holds last link", v, 32'h0A);
    chk("R8 terminal-count irq local", {30'd0, irq_pci, irq_local}, 32'h1);
    wr(5, 32'h08);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int w;
    clear_logs();
    wr(0, 32'h0);
    wr(1, 32'h1000);
    wr(2, 32'h2000);
    wr(3, 32'd200);
    wr(4, 32'h0);
    @(posedge clk);
    ack_en = 1'b0;
    wr(5, 32'h03);
    repeat (3) @(negedge clk);
    rd(5, v);
    chk("R7 done low while busy", {31'd0, v[4]}, 32'd0);
    wr(1, 32'hDEAD_0000);
    wr(5, 32'h05);
    @(posedge clk);
    ack_en = 1'b1;
    wait_done(4, w);
    chk("R10 done within bound", 32'(w < 4), 32'd1);
    chk("R10 only in-flight burst completed", 32'(n_xfer), 32'd1);
    repeat (4) @(negedge clk);
    chk("R10 no burst after abort", 32'(n_xfer), 32'd1);
    rd(1, v); chk("R2 busy write ignored, PCI address", v, 32'h1020);
    rd(3, v); chk("R10 remaining count", v, 32'd168);
    chk("R8 no irq without done enable", {30'd0, irq_pci, irq_local}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem_pci[i] = '0;
      mem_loc[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count_mask();
    t_start_no_enable();
    t_idle_abort();
    t_single();
    t_hold();
    t_chain();
    t_abort();
    summary();
    $finish;
  end

endmodule